// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Unit

This block watches the sixteen already-synchronized input lines of one I/O port and decides, pin by pin, when an interrupt condition has occurred. Each pin can detect either transitions or steady levels. In transition mode it can trigger on a falling edge, a rising edge or both edges. In level mode it can trigger on an active-high or an active-low level. The unit keeps a per-pin status vector and drives one registered interrupt request towards the interrupt controller.

Four configuration words are loaded through a write-only register port: level/edge select, polarity, dual-edge and enable. A fifth address is a write-one-to-clear strobe for the edge status. Edge status bits are sticky. Level status bits track the live condition. The enable word only affects the combined request and never the status vector.

Top module: `pin_irq_detect`

## Requirements
- R1: During and right after reset, `irq_status` is all zero and `irq_req` is 0. All configuration words reset to zero, which means edge mode, falling polarity, single edge and all pins disabled.
- R2: In edge mode (mode bit = 0) with dual bit = 0, a polarity bit of 0 sets the pin's status on a 1-to-0 change and a polarity bit of 1 sets it on a 0-to-1 change. The status is visible one clock after the edge that samples the new level.
- R3: In edge mode with the dual bit = 1, either transition sets the status, whatever the polarity bit holds.
- R4: In level mode (mode bit = 1), the status one clock later equals (pin == polarity bit): 1 selects active high, 0 selects active low. A clear strobe has no effect on it.
- R5: An edge status bit stays set until a write to address 4 carries a 1 in that bit. Zero bits in that write leave status unchanged. An edge detected in the same cycle as the clear keeps the bit set.
- R6: A write to address 0 (mode) or address 1 (polarity) that changes a pin's bit clears that pin's edge status and discards an edge in that cycle. Rewriting the same value does not clear it.
- R7: `irq_req` is the OR over all pins of (status AND enable), registered, so it lags the status vector by one clock.
- R8: The enable word (address 3) gates only `irq_req`. A disabled pin still sets and holds its status.
- R9: Writes to addresses 5, 6 and 7 change no state. Address map: 0 mode, 1 polarity, 2 dual-edge, 3 enable, 4 clear.
- R10: The previous-sample register follows the pin while reset is held, so a level difference present at reset release produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data, one bit per pin |
| irq_status | output | 16 | Per-pin interrupt status |
| irq_req | output | 1 | Combined registered interrupt request |

## Verification
The bench builds the block with its default of sixteen pins and a three-bit address. That is wide enough to reach every address, including the three unused ones, and to run pins in all five trigger modes at the same time. Random writes land on every address while the pins toggle. This brings in the corner cases: a configuration change racing an edge, a clear racing an edge, and an enable change racing a status set. A reset part way through the random traffic repeats the reset-release check with the pins moving.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
package pin_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_POL    = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUAL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 3'd4;

  // transition match for one pin in edge mode
  function automatic logic edge_trigger(input logic dual, input logic pol,
                                        input logic rise, input logic fall);
    if (dual) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // level match for one pin in level mode
  function automatic logic level_trigger(input logic pol, input logic lvl);
    return lvl == pol;
  endfunction
endpackage

// File: rtl/pin_cfg_bank.sv
`timescale 1ns/1ps
module pin_cfg_bank
  import pin_irq_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      dual_q,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      cfg_chg,
  output logic [N-1:0]      clr_req
);
  logic wr_mode, wr_pol, wr_dual, wr_en_word, wr_clr;

  assign wr_mode    = wr_en && (wr_addr == ADDR_MODE);
  assign wr_pol     = wr_en && (wr_addr == ADDR_POL);
  assign wr_dual    = wr_en && (wr_addr == ADDR_DUAL);
  assign wr_en_word = wr_en && (wr_addr == ADDR_ENABLE);
  assign wr_clr     = wr_en && (wr_addr == ADDR_CLEAR);

  assign cfg_chg = ({N{wr_mode}} & (wr_data ^ mode_q)) |
                   ({N{wr_pol}}  & (wr_data ^ pol_q));
  assign clr_req = {N{wr_clr}} & wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      pol_q  <= '0;
      dual_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_mode)    mode_q <= wr_data;
      if (wr_pol)     pol_q  <= wr_data;
      if (wr_dual)    dual_q <= wr_data;
      if (wr_en_word) en_q   <= wr_data;
    end
  end
endmodule

// File: rtl/pin_edge_track.sv
`timescale 1ns/1ps
module pin_edge_track #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  // sampled on every clock, reset included, so release sees no edge
  always_ff @(posedge clk) prev_q <= pin_in;

  assign rise = pin_in & ~prev_q;
  assign fall = ~pin_in & prev_q;
endmodule

// File: rtl/pin_sense_cell.sv
`timescale 1ns/1ps
module pin_sense_cell
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_lvl,
  input  logic rise,
  input  logic fall,
  input  logic mode_lvl,
  input  logic pol,
  input  logic dual,
  input  logic cfg_chg,
  input  logic clr_req,
  output logic edge_hit,
  output logic status_q
);
  logic level_hit, status_d;

  assign edge_hit  = !mode_lvl && edge_trigger(dual, pol, rise, fall);
  assign level_hit = level_trigger(pol, pin_lvl);

  always_comb begin
    if (mode_lvl)      status_d = level_hit;
    else if (cfg_chg)  status_d = 1'b0;
    else if (edge_hit) status_d = 1'b1;
    else if (clr_req)  status_d = 1'b0;
    else               status_d = status_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/pin_irq_detect.sv
`timescale 1ns/1ps
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pin_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [N-1:0]      wr_data,
  output logic [N-1:0]      irq_status,
  output logic              irq_req
);
  logic [N-1:0] mode_q, pol_q, dual_q, en_q;
  logic [N-1:0] cfg_chg, clr_req;
  logic [N-1:0] rise, fall, edge_hit;
  logic         irq_q;

  pin_cfg_bank #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_q(mode_q), .pol_q(pol_q), .dual_q(dual_q),
    .en_q(en_q), .cfg_chg(cfg_chg), .clr_req(clr_req)
  );

  pin_edge_track #(.N(N)) u_edge (
    .clk(clk), .pin_in(pin_in), .rise(rise), .fall(fall)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    pin_sense_cell u_cell (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin_in[i]),
      .rise(rise[i]), .fall(fall[i]),
      .mode_lvl(mode_q[i]), .pol(pol_q[i]), .dual(dual_q[i]),
      .cfg_chg(cfg_chg[i]), .clr_req(clr_req[i]),
      .edge_hit(edge_hit[i]), .status_q(irq_status[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(irq_status & en_q);
  end

  assign irq_req = irq_q;
endmodule

// File: rtl/pin_irq_checks.sv
`timescale 1ns/1ps
module pin_irq_checks #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pin_in,
  input logic [N-1:0] irq_status,
  input logic         irq_req,
  input logic [N-1:0] mode_q,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] edge_hit,
  input logic [N-1:0] cfg_chg,
  input logic [N-1:0] clr_req
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_status == '0) && !irq_req)
    else $error("R1 state not cleared by reset");

  assert_req_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_req == |($past(irq_status) & $past(en_q)))
    else $error("R7 request does not follow enabled status");

  for (genvar i = 0; i < N; i++) begin : g_pin
    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(mode_q[i]) |->
        irq_status[i] == ($past(pin_in[i]) == $past(pol_q[i])))
      else $error("R4 level status mismatch");

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(edge_hit[i]) && !$past(cfg_chg[i]) |-> irq_status[i])
      else $error("R2 edge did not set status");

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(mode_q[i]) && !$past(edge_hit[i]) &&
      !$past(clr_req[i]) && !$past(cfg_chg[i]) |-> $stable(irq_status[i]))
      else $error("R5 edge status not held");

    assert_cfg_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(mode_q[i]) && $past(cfg_chg[i]) |-> !irq_status[i])
      else $error("R6 config change did not clear status");
  end
endmodule

bind pin_irq_detect pin_irq_checks #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .irq_status(irq_status),
  .irq_req(irq_req), .mode_q(mode_q), .pol_q(pol_q), .en_q(en_q),
  .edge_hit(edge_hit), .cfg_chg(cfg_chg), .clr_req(clr_req)
);

// File: tb/sim_pin_irq_detect.sv
`timescale 1ns/1ps
module sim_pin_irq_detect;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_in = 16'h00F0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = 3'd0;
  logic [NP-1:0] wr_data = '0;
  logic [NP-1:0] irq_status;
  logic          irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  pin_irq_detect #(.N(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_status(irq_status),
    .irq_req(irq_req)
  );

  // behavioural reference model
  bit m_mode[NP], m_pol[NP], m_dual[NP], m_en[NP], m_stat[NP], m_prev[NP];
  bit m_irq;

  always @(posedge clk) begin
    bit ns[NP];
    bit any;
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_mode[i] = 0; m_pol[i] = 0; m_dual[i] = 0; m_en[i] = 0;
        m_stat[i] = 0; m_prev[i] = pin_in[i];
      end
      m_irq = 0;
    end else begin
      any = 0;
      for (int i = 0; i < NP; i++) if (m_stat[i] && m_en[i]) any = 1;
      for (int i = 0; i < NP; i++) begin
        bit up, dn, hit, chg, clr;
        up  = pin_in[i] && !m_prev[i];
        dn  = !pin_in[i] && m_prev[i];
        chg = wr_en && ((wr_addr == 0 && wr_data[i] != m_mode[i]) ||
                        (wr_addr == 1 && wr_data[i] != m_pol[i]));
        clr = wr_en && wr_addr == 4 && wr_data[i];
        if (m_dual[i]) hit = up || dn;
        else if (m_pol[i]) hit = up;
        else hit = dn;
        if (m_mode[i]) ns[i] = (pin_in[i] == m_pol[i]);
        else if (chg) ns[i] = 0;
        else if (hit) ns[i] = 1;
        else if (clr) ns[i] = 0;
        else ns[i] = m_stat[i];
      end
      for (int i = 0; i < NP; i++) begin
        if (wr_en) begin
          case (wr_addr)
            3'd0: m_mode[i] = wr_data[i];
            3'd1: m_pol[i]  = wr_data[i];
            3'd2: m_dual[i] = wr_data[i];
            3'd3: m_en[i]   = wr_data[i];
            default: ;
          endcase
        end
        m_stat[i] = ns[i];
        m_prev[i] = pin_in[i];
      end
      m_irq = any;
    end
  end

  task automatic compare_all();
    logic [NP-1:0] exp_s;
    for (int i = 0; i < NP; i++) exp_s[i] = m_stat[i];
    n_cmp++;
    if (irq_status !== exp_s) begin
      n_bad++;
      $display("FAIL %s status actual=%h expected=%h", phase, irq_status, exp_s);
    end
    n_cmp++;
    if (irq_req !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq_req actual=%b expected=%b", phase, irq_req, m_irq);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [NP-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 / R10: pin moves while reset is held
    repeat (3) tick();
    pin_in = 16'h00F1;
    tick();
    rst_n = 1'b1;
    phase = "R10 release";
    tick(); tick();
    expect_bit("R10 no edge at release", |irq_status, 1'b0);
    expect_bit("R1 request low", irq_req, 1'b0);

    write_reg(3'd3, 16'hFFFF);
    phase = "R2 falling";
    pin_in = 16'h00E1;
    tick();
    expect_bit("R2 falling sets bit4", irq_status[4], 1'b1);
    expect_bit("R7 request lags status", irq_req, 1'b0);
    tick();
    expect_bit("R7 request raised", irq_req, 1'b1);

    phase = "R8 enable gate";
    write_reg(3'd3, 16'h0000);
    expect_bit("R8 request one more cycle", irq_req, 1'b1);
    tick();
    expect_bit("R8 request dropped", irq_req, 1'b0);
    expect_bit("R8 status kept", irq_status[4], 1'b1);

    phase = "R5 clear";
    write_reg(3'd4, 16'h0000);
    expect_bit("R5 zero clear keeps bit", irq_status[4], 1'b1);
    write_reg(3'd4, 16'h0010);
    expect_bit("R5 clear drops bit", irq_status[4], 1'b0);

    phase = "R2 rising";
    write_reg(3'd1, 16'h0002);
    pin_in = 16'h00E3;
    tick();
    expect_bit("R2 rising sets bit1", irq_status[1], 1'b1);

    phase = "R6 config change";
    write_reg(3'd1, 16'h0002);
    expect_bit("R6 same value keeps bit", irq_status[1], 1'b1);
    write_reg(3'd1, 16'h0000);
    expect_bit("R6 changed polarity clears", irq_status[1], 1'b0);

    phase = "R3 dual edge";
    write_reg(3'd1, 16'h0004);
    write_reg(3'd2, 16'h0004);
    pin_in = 16'h00E7;
    tick();
    write_reg(3'd4, 16'h0004);
    expect_bit("R3 cleared before fall", irq_status[2], 1'b0);
    pin_in = 16'h00E3;
    tick();
    expect_bit("R3 falling sets with dual", irq_status[2], 1'b1);

    phase = "R4 level";
    write_reg(3'd0, 16'h0100);
    tick();
    expect_bit("R4 active low level", irq_status[8], 1'b1);
    write_reg(3'd4, 16'h0100);
    expect_bit("R4 clear ignored", irq_status[8], 1'b1);
    pin_in = 16'h01E3;
    tick();
    expect_bit("R4 level released", irq_status[8], 1'b0);

    phase = "R9 unused address";
    write_reg(3'd6, 16'hFFFF);
    write_reg(3'd5, 16'hFFFF);
    write_reg(3'd7, 16'hFFFF);
    tick();
    expect_bit("R9 unused writes keep mode", irq_status[8], 1'b0);

    phase = "R2 R3 R4 R5 R6 R7 R8 R9 random";
    for (int c = 0; c < 4000; c++) begin
      if (c == 2000) begin
        phase = "R1 R10 mid reset";
        rst_n = 1'b0;
        pin_in = $urandom;
        tick();
        pin_in = $urandom;
        tick();
        rst_n = 1'b1;
        phase = "R2 R3 R4 R5 R6 R7 R8 R9 random";
      end
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ NP'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_addr = 3'($urandom_range(0, 7));
        wr_data = NP'($urandom);
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule